// File: doc/BRIEF.md
# External Data Bus Cycle Sequencer

This block runs one read or one write on an external memory bus where the low address and the data share one set of pins. A single start pulse samples the direction, a 16-bit address, the write byte and a 3-bit stretch code. The block then steps through a fixed sequence of clocks:

- an address phase with a latch-enable pulse;
- an optional setup clock;
- the active-low read or write strobe;
- an optional hold clock.

The high address byte stays on its own port for the whole cycle. A read returns the byte seen on the shared pins in the last strobe clock. A one-clock done pulse closes every cycle.

The stretch code trades bus time for slack. Code s gives a cycle of (s+2) machine cycles of 4 clocks each, and the strobe is 2+4s clocks wide. Any nonzero code also puts one setup clock before the strobe and one hold clock after it. Slow memories and peripherals can therefore be reached without a change elsewhere. The stretch register inside the block resets to code 1.

Top module: `xbus_seq`

## Requirements
- R1: After reset, ale is 0, rd_n and wr_n are 1, ad_oe is 0, ad_out is 0, busy and done are 0, and rd_data is 0.
- R2: A start accepted at a clock edge makes busy high for exactly (s+2)*4 clocks from the next clock. Here s is the stretch code sampled with start. done is high only in the last of those clocks.
- R3: Clock indices count from 0 at the first busy clock. ale is high in clocks 0 and 1 only. In clocks 0 to 3, ad_oe is 1 and ad_out carries addr[7:0]. hi_addr carries addr[15:8] throughout the cycle.
- R4: The strobe first goes low at clock 4 when s = 0, and at clock 5 when s > 0, which leaves one setup clock.
- R5: The strobe stays low for 2+4s consecutive clocks. Only rd_n moves on a read (wr_sel = 0), and only wr_n moves on a write (wr_sel = 1).
- R6: On a write, ad_oe is 1 and ad_out carries the write byte from clock 4 through the first clock after the strobe rises. Outside the address phase and this window, ad_oe is 0 and ad_out is 0.
- R7: On a read, rd_data takes the value of ad_in from the last clock in which rd_n is low. It then holds until the next read; a write leaves it unchanged.
- R8: A start that arrives while busy is high, including in the done clock, is ignored. The running cycle keeps its sampled direction, address, data and stretch, and no new cycle follows it.
- R9: When s > 0, the strobe rises exactly one clock before the cycle's last clock ends (one hold clock). When s = 0, two clocks follow the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one bus cycle |
| wr_sel | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Write byte |
| stretch | input | 3 | Stretch code s |
| ad_in | input | 8 | Shared pins, input side |
| ad_out | output | 8 | Shared pins, output side |
| ad_oe | output | 1 | Shared pins output enable |
| hi_addr | output | 8 | High address port |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | Last-clock pulse of a cycle |
| busy | output | 1 | Cycle in progress |

## Verification
The bench sweeps all eight stretch codes in both directions. It compares every pin in every clock against values worked out from the cycle arithmetic. A sequencer that forgot the setup clock on stretched cycles would drop its strobe at clock 4 everywhere. One that scaled the strobe wrongly would let done arrive early or late.

Read data is driven with the right byte only in the last strobe clock and with its complement elsewhere. Sampling one clock early or late therefore returns the wrong byte.

Start is pulsed mid-cycle and again in the done clock, with the other inputs changed. A sequencer that accepted either pulse would restart its counter or run a spurious second cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic {
    XB_READ  = 1'b0,
    XB_WRITE = 1'b1
  } xb_dir_e;

  // Clocks in a full cycle for a stretch code, given clocks per machine cycle.
  function automatic int unsigned xb_cycle_clks(input int unsigned code,
                                                input int unsigned mc_clks);
    return (code + 2) * mc_clks;
  endfunction

endpackage

// File: rtl/xbus_timing.sv
module xbus_timing #(
  parameter int STRETCH_W = 3,
  parameter int MC_CLKS   = 4,
  parameter int CNT_W     = 6
) (
  input  logic [STRETCH_W-1:0] stretch_i,
  output logic [CNT_W-1:0]     strobe_first_o,
  output logic [CNT_W-1:0]     strobe_stop_o,
  output logic [CNT_W-1:0]     cycle_last_o
);

  localparam logic [CNT_W-1:0] MC    = CNT_W'(MC_CLKS);
  localparam logic [CNT_W-1:0] HALF  = CNT_W'(MC_CLKS / 2);

  logic [CNT_W-1:0] code_ext;
  logic             stretched;

  always_comb begin
    code_ext       = CNT_W'(stretch_i);
    stretched      = |stretch_i;
    // Setup clock is added only for nonzero codes.
    strobe_first_o = MC + CNT_W'(stretched);
    // Strobe width is half a machine cycle plus one machine cycle per step.
    strobe_stop_o  = strobe_first_o + HALF + (MC * code_ext);
    cycle_last_o   = ((code_ext + CNT_W'(2)) * MC) - CNT_W'(1);
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int STRETCH_W = 3,
  parameter int CNT_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 wr_sel_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [STRETCH_W-1:0] stretch_i,
  input  logic [CNT_W-1:0]     cycle_last_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [CNT_W-1:0]     cnt_o,
  output xb_dir_e              dir_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic [STRETCH_W-1:0] stretch_o
);

  localparam logic [STRETCH_W-1:0] STRETCH_RST = STRETCH_W'(1);

  logic                 busy_q, busy_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  xb_dir_e              dir_q, dir_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [DATA_W-1:0]    wdata_q, wdata_d;
  logic [STRETCH_W-1:0] stretch_q, stretch_d;
  logic                 accept;
  logic                 at_last;
  logic                 req_en;

  assign accept  = start_i && !busy_q;
  assign at_last = busy_q && (cnt_q == cycle_last_i);
  assign req_en  = accept;

  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    dir_d     = dir_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    stretch_d = stretch_q;
    if (req_en) begin
      busy_d    = 1'b1;
      cnt_d     = '0;
      dir_d     = wr_sel_i ? XB_WRITE : XB_READ;
      addr_d    = addr_i;
      wdata_d   = wdata_i;
      stretch_d = stretch_i;
    end else if (busy_q) begin
      if (at_last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      dir_q     <= XB_READ;
      addr_q    <= '0;
      wdata_q   <= '0;
      stretch_q <= STRETCH_RST;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      dir_q     <= dir_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      stretch_q <= stretch_d;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = at_last;
  assign cnt_o     = cnt_q;
  assign dir_o     = dir_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign stretch_o = stretch_q;

  // R8: a request during a cycle leaves the sampled fields untouched
  a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(stretch_q) && $stable(addr_q) &&
                             $stable(dir_q) && $stable(wdata_q)));

  // R2: the done clock is the last busy clock
  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R2: a cycle always starts at index zero
  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == '0));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int MC_CLKS = 4,
  parameter int CNT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  xb_dir_e           dir_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  strobe_first_i,
  input  logic [CNT_W-1:0]  strobe_stop_i,
  input  logic [DATA_W-1:0] ad_in_i,
  output logic [DATA_W-1:0] ad_out_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] hi_addr_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(MC_CLKS);
  localparam logic [CNT_W-1:0] ALE_END  = CNT_W'(MC_CLKS / 2);

  logic              addr_phase;
  logic              in_strobe;
  logic              wr_drive;
  logic              capture;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;

  always_comb begin
    addr_phase = busy_i && (cnt_i < ADDR_END);
    in_strobe  = busy_i && (cnt_i >= strobe_first_i) && (cnt_i < strobe_stop_i);
    wr_drive   = busy_i && (dir_i == XB_WRITE) &&
                 (cnt_i >= ADDR_END) && (cnt_i <= strobe_stop_i);
    capture    = busy_i && (dir_i == XB_READ) &&
                 (cnt_i == (strobe_stop_i - CNT_W'(1)));
  end

  always_comb begin
    ale_o   = busy_i && (cnt_i < ALE_END);
    rd_n_o  = !(in_strobe && (dir_i == XB_READ));
    wr_n_o  = !(in_strobe && (dir_i == XB_WRITE));
    ad_oe_o = addr_phase || wr_drive;
    if (addr_phase)    ad_out_o = addr_i[DATA_W-1:0];
    else if (wr_drive) ad_out_o = wdata_i;
    else               ad_out_o = '0;
    hi_addr_o = addr_i[ADDR_W-1:DATA_W];
  end

  always_comb begin
    rd_data_d = rd_data_q;
    if (capture) rd_data_d = ad_in_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_q <= '0;
    else        rd_data_q <= rd_data_d;
  end

  assign rd_data_o = rd_data_q;

  // R5: the two strobes are never low together
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R3: latch enable and strobes never overlap
  a_r3_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (rd_n_o && wr_n_o));

  // R6: the shared pins are released while the read strobe is low
  a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o);

  // R7: the read byte is taken while the read strobe is low
  a_r7_capture_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !rd_n_o);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int STRETCH_W = 3,
  parameter int MC_CLKS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     wr_sel,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [STRETCH_W-1:0]     stretch,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     done,
  output logic                     busy
);

  localparam int MAX_CLKS = xb_cycle_clks((2 ** STRETCH_W) - 1, MC_CLKS);
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  logic [CNT_W-1:0]     strobe_first;
  logic [CNT_W-1:0]     strobe_stop;
  logic [CNT_W-1:0]     cycle_last;
  logic [CNT_W-1:0]     cnt;
  xb_dir_e              dir;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [STRETCH_W-1:0] stretch_q;

  xbus_timing #(
    .STRETCH_W (STRETCH_W),
    .MC_CLKS   (MC_CLKS),
    .CNT_W     (CNT_W)
  ) u_timing (
    .stretch_i      (stretch_q),
    .strobe_first_o (strobe_first),
    .strobe_stop_o  (strobe_stop),
    .cycle_last_o   (cycle_last)
  );

  xbus_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STRETCH_W (STRETCH_W),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .wr_sel_i     (wr_sel),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .stretch_i    (stretch),
    .cycle_last_i (cycle_last),
    .busy_o       (busy),
    .done_o       (done),
    .cnt_o        (cnt),
    .dir_o        (dir),
    .addr_o       (addr_q),
    .wdata_o      (wdata_q),
    .stretch_o    (stretch_q)
  );

  xbus_pins #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MC_CLKS (MC_CLKS),
    .CNT_W   (CNT_W)
  ) u_pins (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy_i         (busy),
    .cnt_i          (cnt),
    .dir_i          (dir),
    .addr_i         (addr_q),
    .wdata_i        (wdata_q),
    .strobe_first_i (strobe_first),
    .strobe_stop_i  (strobe_stop),
    .ad_in_i        (ad_in),
    .ad_out_o       (ad_out),
    .ad_oe_o        (ad_oe),
    .hi_addr_o      (hi_addr),
    .ale_o          (ale),
    .rd_n_o         (rd_n),
    .wr_n_o         (wr_n),
    .rd_data_o      (rd_data)
  );

  // R2: done is a single-clock pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a stretched strobe is followed by exactly one hold clock before done
  a_r9_hold_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (stretch_q != '0) && $rose(rd_n && wr_n) && !ale && !$rose(busy)) |-> done);

endmodule

// File: tb/xbus_seq_bench.sv
`timescale 1ns/1ps
module xbus_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        wr_sel;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [2:0]  stretch;
  logic [7:0]  ad_in;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  hi_addr;
  logic        ale;
  logic        rd_n;
  logic        wr_n;
  logic [7:0]  rd_data;
  logic        done;
  logic        busy;

  int n_checks;
  int n_fails;
  logic [7:0] exp_rd;

  xbus_seq u_xbus_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_sel(wr_sel), .addr(addr),
    .wdata(wdata), .stretch(stretch), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .hi_addr(hi_addr), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .rd_data(rd_data), .done(done), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle. poke_k >= 0 pulses start at that clock index with changed inputs.
  task automatic run_cycle(input bit w, input int s, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rv,
                           input int poke_k);
    int first_k, stop_k, total;
    bit e_ale, e_oe, e_rd, e_wr, e_done;
    logic [7:0] e_out;
    first_k = 4 + ((s != 0) ? 1 : 0);
    stop_k  = first_k + 2 + 4 * s;
    total   = (s + 2) * 4;
    @(negedge clk);
    start = 1'b1; wr_sel = w; addr = a; wdata = wd; stretch = 3'(s);
    ad_in = ~rv;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < total; k++) begin
      e_ale  = (k < 2);
      e_oe   = (k < 4) || (w && k >= 4 && k <= stop_k);
      e_out  = (k < 4) ? a[7:0] : ((w && k <= stop_k) ? wd : 8'h00);
      e_rd   = !(!w && k >= first_k && k < stop_k);
      e_wr   = !(w && k >= first_k && k < stop_k);
      e_done = (k == total - 1);
      check(busy == 1'b1, "R2 busy", 32'(busy), 32'd1);
      check(done == e_done, "R2 done", 32'(done), 32'(e_done));
      check(ale == e_ale, "R3 ale", 32'(ale), 32'(e_ale));
      check(hi_addr == a[15:8], "R3 hi_addr", 32'(hi_addr), 32'(a[15:8]));
      check(ad_oe == e_oe, "R6 ad_oe", 32'(ad_oe), 32'(e_oe));
      check(ad_out == e_out, "R6 ad_out", 32'(ad_out), 32'(e_out));
      check(rd_n == e_rd, "R4 R5 rd_n", 32'(rd_n), 32'(e_rd));
      check(wr_n == e_wr, "R4 R5 R9 wr_n", 32'(wr_n), 32'(e_wr));
      ad_in = (k == stop_k - 1) ? rv : ~rv;
      if (k == poke_k) begin
        start = 1'b1; wr_sel = ~w; addr = ~a; wdata = ~wd; stretch = 3'(s ^ 5);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (!w) exp_rd = rv;
    check(busy == 1'b0, "R2 R8 busy after done", 32'(busy), 32'd0);
    check(rd_data == exp_rd, "R7 rd_data", 32'(rd_data), 32'(exp_rd));
    @(negedge clk);
    check(busy == 1'b0, "R8 no extra cycle", 32'(busy), 32'd0);
    check(ale == 1'b0, "R8 ale idle", 32'(ale), 32'd0);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; exp_rd = 8'h00;
    rst_n = 1'b0; start = 1'b0; wr_sel = 1'b0; addr = '0; wdata = '0;
    stretch = 3'd1; ad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ale == 1'b0, "R1 ale", 32'(ale), 32'd0);
    check(rd_n == 1'b1, "R1 rd_n", 32'(rd_n), 32'd1);
    check(wr_n == 1'b1, "R1 wr_n", 32'(wr_n), 32'd1);
    check(ad_oe == 1'b0, "R1 ad_oe", 32'(ad_oe), 32'd0);
    check(ad_out == 8'h00, "R1 ad_out", 32'(ad_out), 32'd0);
    check(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
    check(done == 1'b0, "R1 done", 32'(done), 32'd0);
    check(rd_data == 8'h00, "R1 rd_data", 32'(rd_data), 32'd0);

    // Sweep all codes, both directions, several address/data patterns
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 3; p++) begin
        logic [15:0] a;
        logic [7:0]  d;
        a = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : 16'(16'hA53C + s * 16'h1111);
        d = 8'(8'h5A ^ (s * 16 + p));
        run_cycle(1'b0, s, a, d, 8'(d + 8'h33), -1);
        run_cycle(1'b1, s, ~a, ~d, 8'h00, -1);
      end
    end

    // R8: start pulsed mid-cycle and in the done clock
    for (int s = 0; s < 8; s += 3) begin
      run_cycle(1'b0, s, 16'h1234, 8'h77, 8'hC3, 3);
      run_cycle(1'b1, s, 16'hBEEF, 8'h69, 8'h00, (s + 2) * 4 - 1);
      run_cycle(1'b0, s, 16'h4321, 8'h11, 8'h9E, (s + 2) * 4 - 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule